// File: doc/BRIEF.md
# Precise Exception Sequencer

This block decides when a fault in a five-stage in-order pipeline is taken, and what the pipeline must cancel when it is. The stages are fetch, decode, execute, memory and writeback. Fetch, decode, execute and memory each report three things to the block: whether the stage holds an instruction, whether that instruction has faulted, and its PC and cause code. A fault is acted on only when the faulting instruction reaches the memory stage. By then every older instruction is in writeback or has already retired, so those instructions complete normally. The faulting instruction and everything behind it are cancelled, as if they had never been issued.

When a fault is taken, the block latches the faulting PC and its cause code. It raises an in-handler flag and steers fetch to a fixed handler address. A return request sends fetch back to the latched PC and drops the flag. If a fault reaches memory while the handler is running, it is cancelled in the same way but kept waiting in a single pending slot. The next return request then starts the handler again for that waiting fault, instead of resuming the program.

All outputs are registered and change on the clock edge that follows the condition that caused them. The reset is synchronous and active high.

Top module: `exc_seq_ctrl`

## Requirements
- R1: After reset, every output is zero: `kill_o`, `wb_kill_o`, `redir_o`, `redir_pc_o`, `epc_o`, `cause_o` and `in_hdl_o`.
- R2: A fault taken at the memory stage while `in_hdl_o` is 0 loads `epc_o` and `cause_o` on the next edge. The values come from the memory-stage fields, and `in_hdl_o` becomes 1. A fault counts only when the memory stage's valid bit (stage 3) and its fault bit are both set.
- R3: On the edge after a taken or held fault, `kill_o` is all ones and `wb_kill_o` is 1 for exactly one cycle. `kill_o` bit 0 is fetch, 1 is decode, 2 is execute and 3 is memory.
- R4: A taken fault raises `redir_o` for one cycle, with `redir_pc_o` equal to the parameter `HVEC`.
- R5: A fault flag in fetch, decode or execute alone causes no action. A fault flag on an invalid memory stage also causes no action.
- R6: When several stages flag faults in the same cycle, the deepest stage (the oldest instruction) wins, and its PC and cause are the ones latched.
- R7: `eret_i` while `in_hdl_o` is 1, with nothing pending, gives a one-cycle `redir_o` with `redir_pc_o` equal to `epc_o` and clears `in_hdl_o`. `epc_o` and `cause_o` hold their values.
- R8: `eret_i` while `in_hdl_o` is 0 is ignored: no redirect and no state change.
- R9: A fault at the memory stage while `in_hdl_o` is 1 is cancelled as in R3, with no redirect. `epc_o` and `cause_o` are unchanged, and the fault is held pending.
- R10: `eret_i` with a pending fault redirects to `HVEC` and loads `epc_o` and `cause_o` from the pending fault. `in_hdl_o` stays 1.
- R11: The stage inputs are ignored in the cycle in which `wb_kill_o` is high, because they still show cancelled instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_vld_i | input | NRPT | Per-stage valid, bit s = stage s (0 fetch .. 3 memory) |
| stg_flt_i | input | NRPT | Per-stage fault flag |
| stg_pc_i | input | NRPT*PCW | Stage s PC at bits [s*PCW +: PCW] |
| stg_cause_i | input | NRPT*CW | Stage s cause at bits [s*CW +: CW] |
| eret_i | input | 1 | Return-from-handler request |
| kill_o | output | NRPT | Clear valid bits of fetch..memory |
| wb_kill_o | output | 1 | Suppress writeback of the faulting instruction |
| redir_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | PCW | Redirect target |
| epc_o | output | PCW | Saved faulting PC |
| cause_o | output | CW | Saved cause code |
| in_hdl_o | output | 1 | Handler active |

## Verification
The assertions check the following on every cycle:
- A valid memory-stage fault is always followed by a full cancel.
- The cancel pulse never lasts two cycles.
- The saved PC changes only together with a redirect to the handler.
- Entering the handler always goes with a redirect to the handler vector, and leaving it always goes with a redirect to the saved PC.
- Quiet inputs produce no redirect and no cancel.

Only the bench's scenarios show the rest:
- which of several simultaneous faults is taken;
- that a fault in the pending slot survives until the return and then supplies the saved PC and cause;
- that a return with nothing pending is ignored outside the handler.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STG_F = 0;
  localparam int STG_D = 1;
  localparam int STG_E = 2;
  localparam int STG_M = 3;
  localparam int NUM_STG = 5;
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int N   = 4,
  parameter int PCW = 32,
  parameter int CW  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     flt,
  input  logic [N*PCW-1:0] pc,
  input  logic [N*CW-1:0]  cause,
  output logic             hit,
  output logic [IW-1:0]    idx,
  output logic [PCW-1:0]   sel_pc,
  output logic [CW-1:0]    sel_cause
);
  // later (deeper) stages overwrite earlier ones: oldest instruction wins
  always_comb begin
    hit       = 1'b0;
    idx       = '0;
    sel_pc    = '0;
    sel_cause = '0;
    for (int s = 0; s < N; s++) begin
      if (vld[s] && flt[s]) begin
        hit       = 1'b1;
        idx       = IW'(s);
        sel_pc    = pc[s*PCW +: PCW];
        sel_cause = cause[s*CW +: CW];
      end
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int PCW = 32,
  parameter int CW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit,
  input  logic           eret_i,
  input  logic [PCW-1:0] flt_pc,
  input  logic [CW-1:0]  flt_cause,
  output logic [PCW-1:0] epc_q,
  output logic [CW-1:0]  cause_q,
  output logic           in_hdl_q,
  output logic           go_hdl,
  output logic           go_ret
);
  logic           pnd_q;
  logic [PCW-1:0] pnd_pc_q;
  logic [CW-1:0]  pnd_cause_q;
  logic           take, hold, ret, pnd_any;

  assign take    = commit && !in_hdl_q;
  assign hold    = commit && in_hdl_q;
  assign ret     = eret_i && in_hdl_q;
  assign pnd_any = pnd_q || hold;
  assign go_hdl  = take || (ret && pnd_any);
  assign go_ret  = ret && !pnd_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q       <= '0;
      cause_q     <= '0;
      in_hdl_q    <= 1'b0;
      pnd_q       <= 1'b0;
      pnd_pc_q    <= '0;
      pnd_cause_q <= '0;
    end else if (take) begin
      epc_q    <= flt_pc;
      cause_q  <= flt_cause;
      in_hdl_q <= 1'b1;
    end else if (ret && pnd_any) begin
      epc_q   <= pnd_q ? pnd_pc_q : flt_pc;
      cause_q <= pnd_q ? pnd_cause_q : flt_cause;
      pnd_q   <= 1'b0;
    end else if (ret) begin
      in_hdl_q <= 1'b0;
    end else if (hold && !pnd_q) begin
      pnd_q       <= 1'b1;
      pnd_pc_q    <= flt_pc;
      pnd_cause_q <= flt_cause;
    end
  end
endmodule

// File: rtl/exc_steer.sv
module exc_steer #(
  parameter int             N    = 4,
  parameter int             PCW  = 32,
  parameter logic [PCW-1:0] HVEC = 'h180
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit,
  input  logic           go_hdl,
  input  logic           go_ret,
  input  logic [PCW-1:0] epc,
  output logic [N-1:0]   kill_o,
  output logic           wb_kill_o,
  output logic           redir_o,
  output logic [PCW-1:0] redir_pc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kill_o     <= '0;
      wb_kill_o  <= 1'b0;
      redir_o    <= 1'b0;
      redir_pc_o <= '0;
    end else begin
      kill_o     <= commit ? '1 : '0;
      wb_kill_o  <= commit;
      redir_o    <= go_hdl || go_ret;
      redir_pc_o <= go_hdl ? HVEC : (go_ret ? epc : '0);
    end
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl #(
  parameter int             PCW  = 32,
  parameter int             CW   = 5,
  parameter logic [PCW-1:0] HVEC = 'h180,
  localparam int            NRPT = exc_pkg::NUM_STG - 1,
  localparam int            IW   = (NRPT > 1) ? $clog2(NRPT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NRPT-1:0]     stg_vld_i,
  input  logic [NRPT-1:0]     stg_flt_i,
  input  logic [NRPT*PCW-1:0] stg_pc_i,
  input  logic [NRPT*CW-1:0]  stg_cause_i,
  input  logic                eret_i,
  output logic [NRPT-1:0]     kill_o,
  output logic                wb_kill_o,
  output logic                redir_o,
  output logic [PCW-1:0]      redir_pc_o,
  output logic [PCW-1:0]      epc_o,
  output logic [CW-1:0]       cause_o,
  output logic                in_hdl_o
);
  logic           hit, commit, go_hdl, go_ret;
  logic [IW-1:0]  idx;
  logic [PCW-1:0] sel_pc;
  logic [CW-1:0]  sel_cause;

  exc_prio #(.N(NRPT), .PCW(PCW), .CW(CW)) u_prio (
    .vld(stg_vld_i), .flt(stg_flt_i), .pc(stg_pc_i), .cause(stg_cause_i),
    .hit(hit), .idx(idx), .sel_pc(sel_pc), .sel_cause(sel_cause)
  );

  // commit only at memory stage; inputs during a cancel cycle are stale
  assign commit = hit && (idx == IW'(exc_pkg::STG_M)) && !wb_kill_o;

  exc_state #(.PCW(PCW), .CW(CW)) u_state (
    .clk(clk), .rst(rst), .commit(commit), .eret_i(eret_i),
    .flt_pc(sel_pc), .flt_cause(sel_cause),
    .epc_q(epc_o), .cause_q(cause_o), .in_hdl_q(in_hdl_o),
    .go_hdl(go_hdl), .go_ret(go_ret)
  );

  exc_steer #(.N(NRPT), .PCW(PCW), .HVEC(HVEC)) u_steer (
    .clk(clk), .rst(rst), .commit(commit), .go_hdl(go_hdl), .go_ret(go_ret),
    .epc(epc_o), .kill_o(kill_o), .wb_kill_o(wb_kill_o),
    .redir_o(redir_o), .redir_pc_o(redir_pc_o)
  );
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int             NRPT = 4,
  parameter int             PCW  = 32,
  parameter logic [PCW-1:0] HVEC = 'h180
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_vld,
  input logic            mem_flt,
  input logic            eret,
  input logic [NRPT-1:0] kill,
  input logic            wb_kill,
  input logic            redir,
  input logic [PCW-1:0]  redir_pc,
  input logic [PCW-1:0]  epc,
  input logic            in_hdl
);
  AST_COMMIT_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (mem_vld && mem_flt && !wb_kill) |=> (wb_kill && (&kill))); // R3
  AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (rst)
    wb_kill |=> !wb_kill); // R11
  AST_EPC_WITH_VEC: assert property (@(posedge clk) disable iff (rst)
    !$stable(epc) |-> (redir && redir_pc == HVEC)); // R4
  AST_ENTER_VEC: assert property (@(posedge clk) disable iff (rst)
    $rose(in_hdl) |-> (redir && redir_pc == HVEC)); // R4
  AST_LEAVE_EPC: assert property (@(posedge clk) disable iff (rst)
    $fell(in_hdl) |-> (redir && redir_pc == epc)); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!(mem_vld && mem_flt) && !eret) |=> (!redir && !wb_kill)); // R5
endmodule

bind exc_seq_ctrl exc_seq_chk #(.NRPT(NRPT), .PCW(PCW), .HVEC(HVEC)) u_chk (
  .clk(clk), .rst(rst),
  .mem_vld(stg_vld_i[NRPT-1]), .mem_flt(stg_flt_i[NRPT-1]), .eret(eret_i),
  .kill(kill_o), .wb_kill(wb_kill_o), .redir(redir_o), .redir_pc(redir_pc_o),
  .epc(epc_o), .in_hdl(in_hdl_o)
);

// File: tb/sim_exc_seq_ctrl.sv
module sim_exc_seq_ctrl;
  localparam int PCW = 32;
  localparam int CW = 5;
  localparam int N = 4;
  localparam logic [PCW-1:0] HV = 32'h180;

  logic clk = 0, rst = 1, eret = 0;
  logic [N-1:0] vld = '0, flt = '0;
  logic [N*PCW-1:0] pcs = '0;
  logic [N*CW-1:0] cs = '0;
  logic [N-1:0] kill;
  logic wb_kill, redir, in_hdl;
  logic [PCW-1:0] rpc, epc;
  logic [CW-1:0] cause;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_seq_ctrl #(.PCW(PCW), .CW(CW), .HVEC(HV)) u0 (
    .clk(clk), .rst(rst), .stg_vld_i(vld), .stg_flt_i(flt), .stg_pc_i(pcs),
    .stg_cause_i(cs), .eret_i(eret), .kill_o(kill), .wb_kill_o(wb_kill),
    .redir_o(redir), .redir_pc_o(rpc), .epc_o(epc), .cause_o(cause),
    .in_hdl_o(in_hdl)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(int s, logic [PCW-1:0] pc, logic [CW-1:0] c);
    vld[s] = 1; flt[s] = 1;
    pcs[s*PCW +: PCW] = pc;
    cs[s*CW +: CW] = c;
  endtask

  task automatic clr();
    vld = '0; flt = '0; pcs = '0; cs = '0; eret = 0;
  endtask

  task automatic do_ret(logic [PCW-1:0] exp_pc);
    eret = 1; step(); eret = 0;
    chk("R7 redir", redir, 1); chk("R7 pc", rpc, exp_pc); chk("R7 in_hdl", in_hdl, 0);
    step(); chk("R7 pulse", redir, 0);
  endtask

  task automatic t_reset();
    chk("R1 kill", kill, 0); chk("R1 wbk", wb_kill, 0); chk("R1 redir", redir, 0);
    chk("R1 rpc", rpc, 0); chk("R1 epc", epc, 0); chk("R1 cause", cause, 0);
    chk("R1 hdl", in_hdl, 0);
  endtask

  task automatic t_take();
    put(3, 32'h100, 5'd5); step(); clr();
    chk("R2 epc", epc, 32'h100); chk("R2 cause", cause, 5); chk("R2 hdl", in_hdl, 1);
    chk("R3 kill", kill, 4'hF); chk("R3 wbk", wb_kill, 1);
    chk("R4 redir", redir, 1); chk("R4 pc", rpc, HV);
    step();
    chk("R3 kill pulse", kill, 0); chk("R3 wbk pulse", wb_kill, 0); chk("R4 pulse", redir, 0);
    do_ret(32'h100);
    chk("R7 epc hold", epc, 32'h100); chk("R7 cause hold", cause, 5);
  endtask

  task automatic t_idle_ret();
    eret = 1; step(); eret = 0;
    chk("R8 redir", redir, 0); chk("R8 hdl", in_hdl, 0); chk("R8 epc", epc, 32'h100);
  endtask

  task automatic t_young();
    put(0, 32'h40, 1); put(1, 32'h44, 2); put(2, 32'h48, 3); step();
    chk("R5 young wbk", wb_kill, 0); chk("R5 young redir", redir, 0); chk("R5 young hdl", in_hdl, 0);
    clr(); flt[3] = 1; pcs[3*PCW +: PCW] = 32'h4C; step(); clr();
    chk("R5 invalid wbk", wb_kill, 0); chk("R5 invalid epc", epc, 32'h100);
  endtask

  task automatic t_multi();
    put(1, 32'h208, 7); put(2, 32'h204, 8); put(3, 32'h1F8, 3); step(); clr();
    chk("R6 epc", epc, 32'h1F8); chk("R6 cause", cause, 3);
    step(); do_ret(32'h1F8);
  endtask

  task automatic t_stale();
    put(3, 32'h500, 9); step();
    chk("R11 first wbk", wb_kill, 1);
    step(); clr();
    chk("R11 stale wbk", wb_kill, 0); chk("R11 stale kill", kill, 0);
    chk("R11 stale redir", redir, 0); chk("R11 epc", epc, 32'h500);
    do_ret(32'h500);
  endtask

  task automatic t_pend();
    put(3, 32'h300, 1); step(); clr(); step();
    put(3, 32'h340, 2); step(); clr();
    chk("R9 kill", kill, 4'hF); chk("R9 wbk", wb_kill, 1); chk("R9 redir", redir, 0);
    chk("R9 epc", epc, 32'h300); chk("R9 cause", cause, 1);
    step();
    eret = 1; step(); eret = 0;
    chk("R10 redir", redir, 1); chk("R10 pc", rpc, HV); chk("R10 epc", epc, 32'h340);
    chk("R10 cause", cause, 2); chk("R10 hdl", in_hdl, 1);
    step(); do_ret(32'h340);
  endtask

  initial begin
    repeat (3) step();
    rst = 0; #0;
    t_reset();
    step();
    t_take(); t_idle_ret(); t_young(); t_multi(); t_stale(); t_pend();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule